// File: doc/BRIEF.md
# Physical Address Region Decoder

This block sorts every load or store request into the address region it targets. A request carries an address, an access size and a direction flag. The block compares it against four regions: main memory, boot ROM, the core-local timer window and a write-only host mailbox. The base and size of each region, and the mailbox address, are parameters.

The result comes back one clock later from a registered output stage. It is either exactly one region select or an access fault. A fault carries a code that tells a failed load apart from a failed store/AMO. Alongside the result, the block reports whether the address is a readable MMIO location and whether it is a writable MMIO location. A load/store unit uses these flags to report read and write faults separately.

Top module: `pa_region_decoder`

## Requirements
- R1: A request hits a memory or timer region only when base <= addr and addr + bytes <= base + size, both compared unsigned. An access that starts inside a region but runs past its end, or starts below the base, does not hit. Here bytes = 1 << req_size (req_size 0..3 means 1, 2, 4 or 8 bytes).
- R2: rsp_sel bit 0 is main memory, bit 1 is boot ROM, bit 2 is the timer window and bit 3 is the mailbox. For every valid response, exactly one of rsp_sel bits or rsp_fault is set.
- R3: When regions overlap, priority is main memory, then boot ROM, then timer window, then mailbox.
- R4: An access fully contained in the timer window selects the timer for both reads and writes.
- R5: A write whose address equals the mailbox address exactly selects the mailbox (width at most 8 bytes). Any other address near it faults.
- R6: A read of the mailbox address never selects the mailbox and yields a load fault.
- R7: A faulting read returns rsp_fault_code 5. A faulting write returns code 7. The code is 0 when there is no fault.
- R8: rsp_mmio_rd is set when the access is contained in the timer window. rsp_mmio_wr is set when it is contained in the timer window or sits exactly at the mailbox address. Both flags are reported regardless of req_write.
- R9: Limits are computed one bit wider than the address. A region that ends exactly at the top of the address space accepts its last aligned access. An access running past the top faults instead of wrapping.
- R10: rsp_valid equals req_valid delayed by one clock. While rsp_valid is low, all selects, the fault flag, the fault code and both MMIO flags are low.
- R11: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Physical byte address |
| req_size | input | 2 | log2 of access bytes (0..3) |
| req_write | input | 1 | 1 = store/AMO, 0 = load |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_sel | output | 4 | One-hot region select |
| rsp_fault | output | 1 | Access fault |
| rsp_fault_code | output | 4 | 5 load fault, 7 store fault, 0 none |
| rsp_mmio_rd | output | 1 | Address is readable MMIO |
| rsp_mmio_wr | output | 1 | Address is writable MMIO |

## Verification
The main instance uses a 32-bit address. Main memory is placed at 0xF000_0000 with size 0x1000_0000, so that region ends exactly at 2^32; this reaches both the in-range top access and the wrap-around case. Boot ROM is at 0x1000 (4 KiB), the timer window is at 0x0200_0000 (64 KiB) and the mailbox is at 0x4000_0000. A second instance overlaps boot ROM with main memory and places the mailbox at the timer base. With those values, the priority ordering can be observed at the ports.

// File: rtl/pa_dec_pkg.sv
package pa_dec_pkg;

    localparam int NREG = 4;
    localparam int FCW  = 4;

    typedef enum logic [1:0] {
        RG_RAM = 2'd0,
        RG_ROM = 2'd1,
        RG_TMR = 2'd2,
        RG_MBX = 2'd3
    } region_e;

    localparam logic [FCW-1:0] FC_NONE  = 4'd0;
    localparam logic [FCW-1:0] FC_LOAD  = 4'd5;
    localparam logic [FCW-1:0] FC_STORE = 4'd7;

    typedef struct packed {
        logic [NREG-1:0] sel;
        logic            fault;
        logic [FCW-1:0]  code;
        logic            mmio_rd;
        logic            mmio_wr;
    } dec_result_t;

    function automatic logic [3:0] size_to_bytes(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

endpackage

// File: rtl/pa_range_match.sv
module pa_range_match #(
    parameter int              AW   = 32,
    parameter logic [AW-1:0]   BASE = '0,
    parameter logic [AW-1:0]   SIZE = '0
) (
    input  logic [AW-1:0] addr,
    input  logic [3:0]    nbytes,
    output logic          hit
);
    localparam logic [AW:0] LIMIT = {1'b0, BASE} + {1'b0, SIZE};

    logic [AW:0] acc_end;

    always_comb begin
        acc_end = {1'b0, addr} + (AW+1)'(nbytes);
        hit     = (addr >= BASE) && (acc_end <= LIMIT);
    end
endmodule

// File: rtl/pa_mbox_match.sv
module pa_mbox_match #(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] ADDR      = '0,
    parameter int            MAX_BYTES = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [3:0]    nbytes,
    output logic          hit
);
    always_comb begin
        hit = (addr == ADDR) && (int'(nbytes) <= MAX_BYTES);
    end
endmodule

// File: rtl/pa_region_arbiter.sv
module pa_region_arbiter
    import pa_dec_pkg::*;
(
    input  logic        ram_hit,
    input  logic        rom_hit,
    input  logic        tmr_hit,
    input  logic        mbx_hit,
    input  logic        is_write,
    output dec_result_t res
);
    always_comb begin
        res         = '0;
        res.mmio_rd = tmr_hit;
        res.mmio_wr = tmr_hit | mbx_hit;
        if (ram_hit) begin
            res.sel[RG_RAM] = 1'b1;
        end else if (rom_hit) begin
            res.sel[RG_ROM] = 1'b1;
        end else if (tmr_hit) begin
            res.sel[RG_TMR] = 1'b1;
        end else if (mbx_hit && is_write) begin
            res.sel[RG_MBX] = 1'b1;
        end else begin
            res.fault = 1'b1;
            res.code  = is_write ? FC_STORE : FC_LOAD;
        end
    end
endmodule

// File: rtl/pa_region_decoder.sv
module pa_region_decoder
    import pa_dec_pkg::*;
#(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] RAM_BASE  = 32'h8000_0000,
    parameter logic [AW-1:0] RAM_SIZE  = 32'h1000_0000,
    parameter logic [AW-1:0] ROM_BASE  = 32'h0000_1000,
    parameter logic [AW-1:0] ROM_SIZE  = 32'h0000_1000,
    parameter logic [AW-1:0] TMR_BASE  = 32'h0200_0000,
    parameter logic [AW-1:0] TMR_SIZE  = 32'h0001_0000,
    parameter logic [AW-1:0] MBX_ADDR  = 32'h4000_0000,
    parameter int            MBX_BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [AW-1:0]        req_addr,
    input  logic [1:0]           req_size,
    input  logic                 req_write,
    output logic                 rsp_valid,
    output logic [NREG-1:0]      rsp_sel,
    output logic                 rsp_fault,
    output logic [FCW-1:0]       rsp_fault_code,
    output logic                 rsp_mmio_rd,
    output logic                 rsp_mmio_wr
);
    localparam int NRANGE = 3;
    localparam logic [AW-1:0] BASES [NRANGE] = '{RAM_BASE, ROM_BASE, TMR_BASE};
    localparam logic [AW-1:0] SIZES [NRANGE] = '{RAM_SIZE, ROM_SIZE, TMR_SIZE};

    logic [3:0]        nbytes;
    logic [NRANGE-1:0] rng_hit;
    logic              mbx_hit;
    dec_result_t       res_d;
    dec_result_t       res_q;

    assign nbytes = size_to_bytes(req_size);

    for (genvar g = 0; g < NRANGE; g++) begin : g_range
        pa_range_match #(
            .AW   (AW),
            .BASE (BASES[g]),
            .SIZE (SIZES[g])
        ) u_match (
            .addr   (req_addr),
            .nbytes (nbytes),
            .hit    (rng_hit[g])
        );
    end

    pa_mbox_match #(
        .AW        (AW),
        .ADDR      (MBX_ADDR),
        .MAX_BYTES (MBX_BYTES)
    ) u_mbox (
        .addr   (req_addr),
        .nbytes (nbytes),
        .hit    (mbx_hit)
    );

    pa_region_arbiter u_arb (
        .ram_hit  (rng_hit[0]),
        .rom_hit  (rng_hit[1]),
        .tmr_hit  (rng_hit[2]),
        .mbx_hit  (mbx_hit),
        .is_write (req_write),
        .res      (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            res_q     <= req_valid ? res_d : '0;
        end
    end

    assign rsp_sel        = res_q.sel;
    assign rsp_fault      = res_q.fault;
    assign rsp_fault_code = res_q.code;
    assign rsp_mmio_rd    = res_q.mmio_rd;
    assign rsp_mmio_wr    = res_q.mmio_wr;
endmodule

// File: rtl/pa_region_decoder_chk.sv
module pa_region_decoder_chk
    import pa_dec_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_write,
    input logic            rsp_valid,
    input logic [NREG-1:0] rsp_sel,
    input logic            rsp_fault,
    input logic [FCW-1:0]  rsp_fault_code,
    input logic            rsp_mmio_rd,
    input logic            rsp_mmio_wr
);
    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_sel, rsp_fault}) == 1));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_sel == '0 && !rsp_fault && rsp_fault_code == FC_NONE
                        && !rsp_mmio_rd && !rsp_mmio_wr));

    // R10
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R7
    fault_code_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |->
            (rsp_fault_code == ($past(req_write) ? FC_STORE : FC_LOAD)));

    // R7
    no_fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_fault |-> (rsp_fault_code == FC_NONE));

    // R6
    mbx_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_sel[RG_MBX] |-> $past(req_write));

    // R8
    mmio_rd_implies_wr_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_mmio_rd |-> rsp_mmio_wr);
endmodule

bind pa_region_decoder pa_region_decoder_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .rsp_valid      (rsp_valid),
    .rsp_sel        (rsp_sel),
    .rsp_fault      (rsp_fault),
    .rsp_fault_code (rsp_fault_code),
    .rsp_mmio_rd    (rsp_mmio_rd),
    .rsp_mmio_wr    (rsp_mmio_wr)
);

// File: tb/pa_region_decoder_tb.sv
`timescale 1ns/1ps
module pa_region_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;

    logic        rsp_valid,  o_valid;
    logic [3:0]  rsp_sel,    o_sel;
    logic        rsp_fault,  o_fault;
    logic [3:0]  rsp_code,   o_code;
    logic        rsp_rd,     o_rd;
    logic        rsp_wr,     o_wr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pa_region_decoder #(
        .AW(32),
        .RAM_BASE(32'hF000_0000), .RAM_SIZE(32'h1000_0000),
        .ROM_BASE(32'h0000_1000), .ROM_SIZE(32'h0000_1000),
        .TMR_BASE(32'h0200_0000), .TMR_SIZE(32'h0001_0000),
        .MBX_ADDR(32'h4000_0000), .MBX_BYTES(8)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_sel(rsp_sel), .rsp_fault(rsp_fault),
        .rsp_fault_code(rsp_code), .rsp_mmio_rd(rsp_rd), .rsp_mmio_wr(rsp_wr)
    );

    // overlapping layout: ROM inside RAM, mailbox at timer base
    pa_region_decoder #(
        .AW(32),
        .RAM_BASE(32'h8000_0000), .RAM_SIZE(32'h1000_0000),
        .ROM_BASE(32'h8000_0000), .ROM_SIZE(32'h0000_1000),
        .TMR_BASE(32'h4000_0000), .TMR_SIZE(32'h0000_1000),
        .MBX_ADDR(32'h4000_0000), .MBX_BYTES(8)
    ) u_ovl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write),
        .rsp_valid(o_valid), .rsp_sel(o_sel), .rsp_fault(o_fault),
        .rsp_fault_code(o_code), .rsp_mmio_rd(o_rd), .rsp_mmio_wr(o_wr)
    );

    task automatic compare(input string tag, input logic [3:0] a_sel, input logic a_f,
                           input logic [3:0] a_c, input logic a_rd, input logic a_wr,
                           input logic a_v,
                           input logic [3:0] e_sel, input logic e_f, input logic [3:0] e_c,
                           input logic e_rd, input logic e_wr, input logic e_v);
        n_checks++;
        if ({a_v, a_sel, a_f, a_c, a_rd, a_wr} !== {e_v, e_sel, e_f, e_c, e_rd, e_wr}) begin
            n_fail++;
            $display("FAIL %s: got v=%b sel=%b f=%b code=%0d rd=%b wr=%b, want v=%b sel=%b f=%b code=%0d rd=%b wr=%b",
                     tag, a_v, a_sel, a_f, a_c, a_rd, a_wr, e_v, e_sel, e_f, e_c, e_rd, e_wr);
        end
    endtask

    // drive one request at a falling edge, sample just after the next rising edge
    task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic wr);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = sz;
        req_write = wr;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_dut(input string tag, input logic [3:0] s, input logic f,
                              input logic [3:0] c, input logic rd, input logic wr);
        compare(tag, rsp_sel, rsp_fault, rsp_code, rsp_rd, rsp_wr, rsp_valid,
                s, f, c, rd, wr, 1'b1);
    endtask

    task automatic expect_ovl(input string tag, input logic [3:0] s, input logic f,
                              input logic [3:0] c, input logic rd, input logic wr);
        compare(tag, o_sel, o_fault, o_code, o_rd, o_wr, o_valid,
                s, f, c, rd, wr, 1'b1);
    endtask

    task automatic t_reset();
        // R11
        compare("R11 reset", rsp_sel, rsp_fault, rsp_code, rsp_rd, rsp_wr, rsp_valid,
                4'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_memory();
        issue(32'hF000_0000, 2'd2, 1'b0);
        expect_dut("R1 ram read base", 4'b0001, 0, 0, 0, 0);
        issue(32'h0000_1FFC, 2'd2, 1'b0);
        expect_dut("R1 rom last word", 4'b0010, 0, 0, 0, 0);
        issue(32'h0000_1FFE, 2'd2, 1'b0);
        expect_dut("R1 rom overrun", 4'b0000, 1, 5, 0, 0);
        issue(32'h0000_0FFF, 2'd0, 1'b1);
        expect_dut("R1 below rom base", 4'b0000, 1, 7, 0, 0);
    endtask

    task automatic t_top_of_space();
        issue(32'hFFFF_FFF8, 2'd3, 1'b1);
        expect_dut("R9 top aligned dword", 4'b0001, 0, 0, 0, 0);
        issue(32'hFFFF_FFFC, 2'd3, 1'b0);
        expect_dut("R9 wrap past top", 4'b0000, 1, 5, 0, 0);
    endtask

    task automatic t_timer();
        issue(32'h0200_FFF8, 2'd3, 1'b0);
        expect_dut("R4 R8 timer read end", 4'b0100, 0, 0, 1, 1);
        issue(32'h0200_0000, 2'd2, 1'b1);
        expect_dut("R4 timer write", 4'b0100, 0, 0, 1, 1);
        issue(32'h0200_FFFC, 2'd3, 1'b1);
        expect_dut("R1 R8 timer overrun", 4'b0000, 1, 7, 0, 0);
    endtask

    task automatic t_mailbox();
        issue(32'h4000_0000, 2'd3, 1'b1);
        expect_dut("R5 mailbox write", 4'b1000, 0, 0, 0, 1);
        expect_ovl("R3 timer over mailbox", 4'b0100, 0, 0, 1, 1);
        issue(32'h4000_0004, 2'd2, 1'b1);
        expect_dut("R5 mailbox off addr", 4'b0000, 1, 7, 0, 0);
        issue(32'h4000_0000, 2'd2, 1'b0);
        expect_dut("R6 R8 mailbox read", 4'b0000, 1, 5, 0, 1);
    endtask

    task automatic t_faults_priority();
        issue(32'h0000_0000, 2'd1, 1'b1);
        expect_dut("R7 unmapped write", 4'b0000, 1, 7, 0, 0);
        issue(32'h0000_0000, 2'd1, 1'b0);
        expect_dut("R7 unmapped read", 4'b0000, 1, 5, 0, 0);
        issue(32'h8000_0000, 2'd2, 1'b0);
        expect_ovl("R3 ram over rom", 4'b0001, 0, 0, 0, 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 32'hF000_0000;
        @(posedge clk);
        #1;
        // R10
        compare("R10 idle", rsp_sel, rsp_fault, rsp_code, rsp_rd, rsp_wr, rsp_valid,
                4'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_memory();
        t_top_of_space();
        t_timer();
        t_mailbox();
        t_faults_priority();
        t_idle();
        finish_run();
    end

    initial begin
        #20000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, want completion");
        finish_run();
    end

endmodule